// File: doc/BRIEF.md
# Scan-Line Interrupt Unit

This block raises interrupts at chosen points of a video frame. It watches the vertical line counter and the horizontal pixel counter of a display timing generator. It holds one target line for each of its interrupt sources. When the beam reaches the first pixel of a source's target line, the unit latches a sticky status bit for that source. Software reads the latched bits, picks which of them reach the single interrupt output, and acknowledges a bit by writing a one to it in a separate clear register.

A second register holds two further target lines for context loading: one for the double-buffered load and one for the single-buffered load. Each of them produces a pulse one clock wide when the beam reaches the start of its line. These pulses are never latched and no mask applies to them. A target line of zero matches the first line of the frame, so a source set to zero can act as the frame-start or vertical-blank event. The block does not generate timing. It only compares the counters it receives.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset, every target line, the mask and the status are zero, and `irq`, `db_pulse` and `sb_pulse` are low.
- R2: The register map is: target line of source i at byte offset 4*i (i = 0..3, line in bits 12:0), status at 0x10 (source i in bit i, read-only), clear at 0x14 (reads as zero), mask at 0x18 (source i in bit i), and context-load lines at 0x1C (double-buffer line in bits 12:0, single-buffer line in bits 28:16). All other bits read as zero. A write takes effect at the clock edge on which `reg_wr` is sampled high, and reads are combinational.
- R3: Status bit i becomes 1 at the clock edge that ends a cycle in which `pix_pos` is 0 and `line_pos` equals target line i. It is therefore visible from the next cycle. A target of 0 matches the first line, and a target beyond the last line never matches.
- R4: A status bit, once set, stays set whatever the mask holds. Writing a 0 to its clear bit leaves it unchanged.
- R5: Writing a 1 to bit i of the clear register clears status bit i at that edge.
- R6: If a set event and a clear of the same bit fall on the same edge, the bit ends up set.
- R7: `irq` is high exactly when some source has both its status bit and its mask bit at 1. It follows a mask change in the cycle after the write.
- R8: `db_pulse` is high for exactly the one cycle that follows a cycle in which `pix_pos` is 0 and `line_pos` equals the double-buffer line. This gives one pulse per frame.
- R9: `sb_pulse` behaves in the same way for the single-buffer line.
- R10: A write to the status offset does not change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| line_pos | input | LINE_W (13) | Current vertical line from the timing generator |
| pix_pos | input | HPOS_W (13) | Current horizontal pixel position, 0 at line start |
| irq | output | 1 | Combined interrupt (status AND mask, ORed) |
| db_pulse | output | 1 | Double-buffer context-load pulse |
| sb_pulse | output | 1 | Single-buffer context-load pulse |

## Verification
A status bit and the two pulses are due one cycle after the cycle in which the counters match. `irq` is due in the same cycle as the status bit or mask change that drives it. Register reads are due within the same cycle. The bench drives every input at the falling edge and updates its model at the rising edge, using the inputs that edge samples. It then compares `irq`, both pulses and a combinational status read at the next falling edge, so each result is checked in the first cycle it is due. Sweeps over every target line of a short frame show that the event lands on the right line and occurs exactly once per frame.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   localparam int unsigned REG_AW  = 8;
   localparam int unsigned REG_DW  = 32;
   localparam int unsigned MAX_SRC = 4;
   localparam int unsigned SB_LSB  = 16;

   localparam logic [REG_AW-1:0] A_TRIG_BASE = 8'h00;
   localparam logic [REG_AW-1:0] A_STAT      = 8'h10;
   localparam logic [REG_AW-1:0] A_CLR       = 8'h14;
   localparam logic [REG_AW-1:0] A_MASK      = 8'h18;
   localparam logic [REG_AW-1:0] A_CTX       = 8'h1C;

   function automatic logic [REG_AW-1:0] trig_addr(input int unsigned idx);
      return A_TRIG_BASE + REG_AW'(idx * 4);
   endfunction
endpackage

// File: rtl/lirq_src.sv
module lirq_src #(
   parameter int unsigned LINE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_now,
   input  logic [LINE_W-1:0] target,
   input  logic              clr,
   output logic              stat_q
);
   logic hit;
   assign hit = line_start && (line_now == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stat_q <= 1'b0;
      else if (hit) stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
   end
endmodule

// File: rtl/lirq_pulse.sv
module lirq_pulse #(
   parameter int unsigned LINE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_now,
   input  logic [LINE_W-1:0] target,
   output logic              pulse_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= line_start && (line_now == target);
   end
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int unsigned LINE_W  = 13,
   parameter int unsigned NUM_SRC = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr,
   input  logic [REG_AW-1:0]               addr,
   input  logic [REG_DW-1:0]               wdata,
   input  logic [NUM_SRC-1:0]              status,
   output logic [REG_DW-1:0]               rdata,
   output logic [NUM_SRC-1:0][LINE_W-1:0]  trig_q,
   output logic [NUM_SRC-1:0]              mask_q,
   output logic [LINE_W-1:0]               db_q,
   output logic [LINE_W-1:0]               sb_q,
   output logic [NUM_SRC-1:0]              clr
);
   assign clr = (wr && addr == A_CLR) ? wdata[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
         mask_q <= '0;
         db_q   <= '0;
         sb_q   <= '0;
      end else if (wr) begin
         for (int i = 0; i < NUM_SRC; i++)
            if (addr == trig_addr(i)) trig_q[i] <= wdata[LINE_W-1:0];
         if (addr == A_MASK) mask_q <= wdata[NUM_SRC-1:0];
         if (addr == A_CTX) begin
            db_q <= wdata[LINE_W-1:0];
            sb_q <= wdata[SB_LSB +: LINE_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (addr == trig_addr(i)) rdata[LINE_W-1:0] = trig_q[i];
      if (addr == A_STAT) rdata[NUM_SRC-1:0] = status;
      if (addr == A_MASK) rdata[NUM_SRC-1:0] = mask_q;
      if (addr == A_CTX) begin
         rdata[LINE_W-1:0]      = db_q;
         rdata[SB_LSB +: LINE_W] = sb_q;
      end
   end
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
   import lirq_pkg::*;
#(
   parameter int unsigned LINE_W  = 13,
   parameter int unsigned HPOS_W  = 13,
   parameter int unsigned NUM_SRC = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [lirq_pkg::REG_AW-1:0] reg_addr,
   input  logic [lirq_pkg::REG_DW-1:0] reg_wdata,
   output logic [lirq_pkg::REG_DW-1:0] reg_rdata,
   input  logic [LINE_W-1:0]          line_pos,
   input  logic [HPOS_W-1:0]          pix_pos,
   output logic                       irq,
   output logic                       db_pulse,
   output logic                       sb_pulse
);
   localparam int unsigned N_CTX = 2;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must lie in 1..4");
   end
   if (LINE_W < 1 || LINE_W > SB_LSB) begin : g_bad_line
      $error("LINE_W must lie in 1..16");
   end

   logic [NUM_SRC-1:0]             stat_q;
   logic [NUM_SRC-1:0]             mask_q;
   logic [NUM_SRC-1:0]             clr;
   logic [NUM_SRC-1:0][LINE_W-1:0] trig_q;
   logic [LINE_W-1:0]              db_q;
   logic [LINE_W-1:0]              sb_q;
   logic [N_CTX-1:0][LINE_W-1:0]   ctx_lines;
   logic [N_CTX-1:0]               ctx_pulse;
   logic                           line_start;

   assign line_start = (pix_pos == '0);

   lirq_regs #(.LINE_W(LINE_W), .NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .status(stat_q), .rdata(reg_rdata), .trig_q(trig_q), .mask_q(mask_q),
      .db_q(db_q), .sb_q(sb_q), .clr(clr)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      lirq_src #(.LINE_W(LINE_W)) u_src (
         .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_now(line_pos),
         .target(trig_q[i]), .clr(clr[i]), .stat_q(stat_q[i])
      );
   end

   assign ctx_lines = {sb_q, db_q};

   for (genvar k = 0; k < N_CTX; k++) begin : g_ctx
      lirq_pulse #(.LINE_W(LINE_W)) u_pulse (
         .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_now(line_pos),
         .target(ctx_lines[k]), .pulse_q(ctx_pulse[k])
      );
   end

   assign db_pulse = ctx_pulse[0];
   assign sb_pulse = ctx_pulse[1];
   assign irq      = |(stat_q & mask_q);
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
   import lirq_pkg::*;
#(
   parameter int unsigned LINE_W  = 13,
   parameter int unsigned HPOS_W  = 13,
   parameter int unsigned NUM_SRC = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           reg_wr,
   input logic [REG_AW-1:0]              reg_addr,
   input logic [REG_DW-1:0]              reg_wdata,
   input logic [LINE_W-1:0]              line_pos,
   input logic [HPOS_W-1:0]              pix_pos,
   input logic [NUM_SRC-1:0]             status,
   input logic [NUM_SRC-1:0][LINE_W-1:0] trig,
   input logic [LINE_W-1:0]              db_line,
   input logic [LINE_W-1:0]              sb_line,
   input logic                           irq,
   input logic                           db_pulse,
   input logic                           sb_pulse
);
   logic [NUM_SRC-1:0] hit;
   logic [NUM_SRC-1:0] clr_w;
   logic               mask_wr;
   logic               stat_wr;

   always_comb
      for (int i = 0; i < NUM_SRC; i++)
         hit[i] = (pix_pos == '0) && (line_pos == trig[i]);

   assign clr_w   = (reg_wr && reg_addr == A_CLR) ? reg_wdata[NUM_SRC-1:0] : '0;
   assign mask_wr = reg_wr && reg_addr == A_MASK;
   assign stat_wr = reg_wr && reg_addr == A_STAT;

   a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit)));

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (|status) |=> (($past(status) & ~status & ~$past(clr_w)) == '0));

   a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hit & clr_w)) |=> ((status & $past(hit & clr_w)) == $past(hit & clr_w)));

   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(|hit) || $past(mask_wr)));

   a_r8_db_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      db_pulse |-> ($past(pix_pos) == '0 && $past(line_pos) == $past(db_line)));

   a_r9_sb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sb_pulse |-> ($past(pix_pos) == '0 && $past(line_pos) == $past(sb_line)));

   a_r10_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && hit == '0) |=> $stable(status));
endmodule

bind line_irq_ctrl lirq_chk #(.LINE_W(LINE_W), .HPOS_W(HPOS_W), .NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .line_pos(line_pos), .pix_pos(pix_pos), .status(stat_q), .trig(trig_q),
   .db_line(db_q), .sb_line(sb_q), .irq(irq), .db_pulse(db_pulse), .sb_pulse(sb_pulse)
);

// File: tb/tb_line_irq_ctrl.sv
module tb_line_irq_ctrl;
   import lirq_pkg::*;
   localparam int LW = 13, HW = 13, NS = 4;
   localparam int H_TOT = 6, V_TOT = 8;
   localparam int FRAME = H_TOT * V_TOT;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              reg_wr = 1'b0;
   logic [REG_AW-1:0] reg_addr = A_STAT;
   logic [REG_DW-1:0] reg_wdata = '0;
   logic [REG_DW-1:0] reg_rdata;
   logic [LW-1:0]     line_pos = '0;
   logic [HW-1:0]     pix_pos = '0;
   logic              irq, db_pulse, sb_pulse;

   line_irq_ctrl #(.LINE_W(LW), .HPOS_W(HW), .NUM_SRC(NS)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .line_pos(line_pos), .pix_pos(pix_pos),
      .irq(irq), .db_pulse(db_pulse), .sb_pulse(sb_pulse)
   );

   int checks = 0, errors = 0;
   int db_cnt = 0, sb_cnt = 0;
   logic [NS-1:0] m_stat = '0, m_mask = '0;
   logic [LW-1:0] m_trig [NS];
   logic [LW-1:0] m_db = '0, m_sb = '0;
   logic          m_dbp = 1'b0, m_sbp = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic tick();
      logic [NS-1:0] hit, clr;
      @(posedge clk);
      for (int i = 0; i < NS; i++) hit[i] = (pix_pos == 0) && (line_pos == m_trig[i]);
      clr   = (reg_wr && reg_addr == A_CLR) ? reg_wdata[NS-1:0] : '0;
      m_dbp = (pix_pos == 0) && (line_pos == m_db);
      m_sbp = (pix_pos == 0) && (line_pos == m_sb);
      m_stat = (m_stat & ~clr) | hit;
      if (reg_wr) begin
         for (int i = 0; i < NS; i++)
            if (reg_addr == REG_AW'(4 * i)) m_trig[i] = reg_wdata[LW-1:0];
         if (reg_addr == A_MASK) m_mask = reg_wdata[NS-1:0];
         if (reg_addr == A_CTX) begin
            m_db = reg_wdata[12:0];
            m_sb = reg_wdata[28:16];
         end
      end
      @(negedge clk);
      reg_wr   = 1'b0;
      reg_addr = A_STAT;
      if (int'(pix_pos) == H_TOT - 1) begin
         pix_pos  = '0;
         line_pos = (int'(line_pos) == V_TOT - 1) ? '0 : line_pos + 1'b1;
      end else pix_pos = pix_pos + 1'b1;
      #1;
      chk("R7 irq", 32'(irq), 32'(|(m_stat & m_mask)));
      chk("R8 db_pulse", 32'(db_pulse), 32'(m_dbp));
      chk("R9 sb_pulse", 32'(sb_pulse), 32'(m_sbp));
      chk("R3/R4/R5 status", reg_rdata, 32'(m_stat));
      if (db_pulse) db_cnt++;
      if (sb_pulse) sb_cnt++;
   endtask

   task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
   endtask

   task automatic rd(input string req, input logic [REG_AW-1:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp);
      reg_addr = A_STAT;
      #1;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int i = 0; i < NS; i++) m_trig[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 db_pulse", 32'(db_pulse), 0);
      chk("R1 sb_pulse", 32'(sb_pulse), 0);
      for (int i = 0; i < NS; i++) rd("R1 trig", REG_AW'(4 * i), 0);
      rd("R1 status", A_STAT, 0);
      rd("R1 mask", A_MASK, 0);
      rd("R1 ctx", A_CTX, 0);
      rst_n = 1'b1;

      // R2: programming and readback
      wr(8'h04, 32'hFFFF_E003);
      wr(8'h08, 32'd5);
      wr(8'h0C, 32'd7);
      wr(A_CTX, 32'hE002_E006);
      rd("R2 trig0", 8'h00, 0);
      rd("R2 trig1", 8'h04, 3);
      rd("R2 trig2", 8'h08, 5);
      rd("R2 trig3", 8'h0C, 7);
      rd("R2 ctx", A_CTX, 32'h0002_0006);
      rd("R2 clear reads zero", A_CLR, 0);
      rd("R2 unmapped", 8'h20, 0);

      // R3/R4: all sources latch over two frames with mask off
      run(2 * FRAME);
      rd("R4 status sticky unmasked", A_STAT, 32'hF);
      chk("R4 irq masked off", 32'(irq), 0);

      wr(A_MASK, 32'h2);
      chk("R7 irq on mask", 32'(irq), 1);
      rd("R2 mask", A_MASK, 2);
      wr(A_CLR, 32'h2);
      chk("R5 irq after clear", 32'(irq), 0);
      rd("R5 status after clear", A_STAT, 32'hD);
      wr(A_STAT, 32'h0);
      rd("R10 status write ignored", A_STAT, 32'(m_stat));
      wr(A_CLR, 32'h0);
      rd("R4 zero clear ignored", A_STAT, 32'(m_stat));

      // R6: clear on the same edge as a set of source 1
      wr(A_CLR, 32'hF);
      while (!(line_pos == 3 && pix_pos == 0)) tick();
      wr(A_CLR, 32'hF);
      chk("R6 set wins", 32'(reg_rdata[1]), 1);

      // R3: sweep the target of source 0 across and beyond the frame
      wr(A_MASK, 32'h1);
      for (int v = 0; v <= V_TOT; v++) begin
         wr(8'h00, 32'(v));
         wr(A_CLR, 32'hF);
         run(FRAME);
         rd("R3 sweep", A_STAT, 32'(m_stat));
         chk("R3 sweep bit0", 32'(m_stat[0]), 32'(v < V_TOT));
      end

      // R8/R9: one pulse per frame for every line value
      for (int v = 0; v < V_TOT; v++) begin
         wr(A_CTX, {3'b0, 13'(V_TOT - 1 - v), 3'b0, 13'(v)});
         run(H_TOT);
         db_cnt = 0; sb_cnt = 0;
         run(FRAME);
         chk("R8 db pulses per frame", 32'(db_cnt), 1);
         chk("R9 sb pulses per frame", 32'(sb_cnt), 1);
      end
      summary();
   end
endmodule